// File: doc/BRIEF.md
# Parallel Deconvolution Multiply-Accumulate Engine

The engine is the arithmetic core of a strided deconvolution layer. Each accepted step carries one vector of input-channel pixels, a full output-by-input weight matrix for one kernel offset, and the index of the output-tile location that the step updates. A grid of signed multipliers forms every pixel-weight product at once. A balanced adder tree per output channel then reduces the products, and the reduced sums are added into an on-chip output tile that holds full-precision partial results. The engine does not generate addresses. The sequencer upstream walks the kernel offsets and the output positions and sends a location index with each step.

Consecutive steps that target the same location are merged in a holding register and do not each cause a tile write. The tile is written only when the stream moves to another location. Reads of the tile add the held partial sum to the stored value, so a read always returns the complete total. A clear request first lets the in-flight steps leave the multiplier pipeline. It then discards them, together with the held partial sum and every stored location, in a single cycle. Values read out are saturated to the operand width. Accumulation inside the tile keeps guard bits, so intermediate overflow is never lost.

Top module: `dmac_engine`

## Requirements
- R1: After reset `inReady` is 1 and every tile location reads back as zero in all output-channel lanes.
- R2: One accepted step adds, for each output channel `oc`, the sum over `ic` of `pix[ic] * wgt[oc][ic]` to the addressed location. All values are signed two's complement. Pixel `ic` sits at `inPix[ic*DW +: DW]`, weight `(oc,ic)` sits at `inWgt[(oc*TIC+ic)*DW +: DW]`, and lane `oc` of the result sits at `rdData[oc*DW +: DW]`. Other locations do not change.
- R3: Back-to-back steps to the same location accumulate exactly. The holding register merges them, and the tile is never written twice in a row at one address.
- R4: Steps that return to a location after other locations were updated in between add to the value already stored there.
- R5: The read-out value is the accumulated total clamped to the range -2048..2047 (for DW=12). The internal sum keeps full precision, so a total that overflows and later returns into range reads back exactly.
- R6: A step is taken only in a cycle where both `inValid` and `inReady` are high. Pixels, weights and addresses presented while `inValid` is low do not change any location.
- R7: A one-cycle `clearTile` pulse drops `inReady` in the following cycle and holds it low until the multiplier pipeline is empty. Every location is then zeroed, including steps accepted before the pulse that had not yet reached the tile. After that `inReady` returns to 1.
- R8: A read of the location held in the merge register returns the stored value plus the held partial sum.
- R9: A step accepted at clock edge n appears in `rdData` after edge n+3 when `rdAddr` already points at its location. After edge n+2, `rdData` still shows the previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clearTile | input | 1 | Request to drain the pipeline and zero the tile |
| inValid | input | 1 | Step data present |
| inReady | output | 1 | Engine can take a step this cycle |
| inPix | input | TIC*DW | Input-channel pixel vector |
| inWgt | input | TOC*TIC*DW | Weight matrix for one kernel offset |
| inAddr | input | AW | Output-tile location index of the step |
| rdAddr | input | AW | Tile location to read |
| rdData | output | TOC*DW | Saturated per-lane total, one cycle after rdAddr |

## Verification
The bench builds the engine with its defaults: DW=12, TIC=4, TOC=2 and DEPTH=16. Four input lanes give a full two-level adder tree with no padding. Two output lanes show that each lane takes its own row of the weight matrix. With 12-bit operands, extreme pixel and weight values drive the total past both saturation limits in a single step, and a second step brings it back into range. Sixteen locations are few enough to sweep completely after reset and after a clear.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic accept;  // a step enters the multiplier grid
    logic wipe;    // drop held sum and mark every tile location empty
  } dmacStrobe_t;
endpackage

// File: rtl/dmac_mulgrid.sv
module dmac_mulgrid #(
  parameter int DW    = 12,
  parameter int TIC   = 4,
  parameter int TOC   = 2,
  parameter int AW    = 4,
  parameter int GUARD = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   accept,
  input  logic [TIC*DW-1:0]      inPix,
  input  logic [TOC*TIC*DW-1:0]  inWgt,
  input  logic [AW-1:0]          inAddr,
  output logic                   sumValid,
  output logic [AW-1:0]          sumAddr,
  output logic [TOC*(2*DW+$clog2(TIC)+GUARD)-1:0] sumFlat,
  output logic                   gridBusy
);
  localparam int PW   = 2 * DW;
  localparam int LVL  = $clog2(TIC);
  localparam int NP   = 1 << LVL;
  localparam int ACCW = PW + LVL + GUARD;
  localparam int NPROD = TOC * TIC;

  logic signed [PW-1:0] prodD [NPROD];
  logic signed [PW-1:0] prodQ [NPROD];
  logic                 prodValid;
  logic [AW-1:0]        prodAddr;
  logic signed [ACCW-1:0] sumQ [TOC];

  // Multiplier grid: one product per (oc, ic) pair
  for (genvar o = 0; o < TOC; o++) begin : g_row
    for (genvar i = 0; i < TIC; i++) begin : g_col
      assign prodD[o*TIC+i] = PW'($signed(inWgt[(o*TIC+i)*DW +: DW]))
                            * PW'($signed(inPix[i*DW +: DW]));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prodValid <= 1'b0;
      prodAddr  <= '0;
    end else begin
      prodValid <= accept;
      if (accept) prodAddr <= inAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      for (int k = 0; k < NPROD; k++) prodQ[k] <= prodD[k];
    end
  end

  // One balanced adder tree per output channel, heap-indexed
  for (genvar o = 0; o < TOC; o++) begin : g_tree
    logic signed [ACCW-1:0] node [2*NP-1];
    for (genvar k = 0; k < NP; k++) begin : g_leaf
      if (k < TIC) begin : g_used
        assign node[NP-1+k] = ACCW'(prodQ[o*TIC+k]);
      end else begin : g_pad
        assign node[NP-1+k] = '0;
      end
    end
    for (genvar k = 0; k < NP-1; k++) begin : g_inner
      assign node[k] = node[2*k+1] + node[2*k+2];
    end
    always_ff @(posedge clk) begin
      if (prodValid) sumQ[o] <= node[0];
    end
    assign sumFlat[o*ACCW +: ACCW] = sumQ[o];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sumValid <= 1'b0;
      sumAddr  <= '0;
    end else begin
      sumValid <= prodValid;
      if (prodValid) sumAddr <= prodAddr;
    end
  end

  assign gridBusy = prodValid | sumValid;

  // R6
  idle_no_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    !accept |=> !prodValid);
  // R9
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    prodValid |=> sumValid);
  // R9
  no_phantom_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    !prodValid |=> !sumValid);
endmodule

// File: rtl/dmac_datapath.sv
module dmac_datapath
  import dmac_pkg::*;
#(
  parameter int DW    = 12,
  parameter int TIC   = 4,
  parameter int TOC   = 2,
  parameter int DEPTH = 16,
  parameter int GUARD = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  dmacStrobe_t               strobes,
  input  logic [TIC*DW-1:0]         inPix,
  input  logic [TOC*TIC*DW-1:0]     inWgt,
  input  logic [$clog2(DEPTH)-1:0]  inAddr,
  input  logic [$clog2(DEPTH)-1:0]  rdAddr,
  output logic [TOC*DW-1:0]         rdData,
  output logic                      pipeBusy
);
  localparam int AW   = $clog2(DEPTH);
  localparam int ACCW = 2*DW + $clog2(TIC) + GUARD;
  localparam logic signed [ACCW-1:0] HIV = ACCW'((2**(DW-1)) - 1);
  localparam logic signed [ACCW-1:0] LOV = ~HIV;

  logic                  sumValid;
  logic [AW-1:0]         sumAddr;
  logic [TOC*ACCW-1:0]   sumFlat;

  dmac_mulgrid #(.DW(DW), .TIC(TIC), .TOC(TOC), .AW(AW), .GUARD(GUARD)) i_grid (
    .clk      (clk),
    .rstN     (rstN),
    .accept   (strobes.accept),
    .inPix    (inPix),
    .inWgt    (inWgt),
    .inAddr   (inAddr),
    .sumValid (sumValid),
    .sumAddr  (sumAddr),
    .sumFlat  (sumFlat),
    .gridBusy (pipeBusy)
  );

  // Holding register: merges runs of updates to one location
  logic                   holdValid;
  logic [AW-1:0]          holdAddr;
  logic signed [ACCW-1:0] holdSum [TOC];
  logic                   sameLoc;
  logic                   memWe;

  assign sameLoc = holdValid && sumValid && (sumAddr == holdAddr);
  assign memWe   = holdValid && sumValid && !sameLoc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdAddr  <= '0;
      for (int o = 0; o < TOC; o++) holdSum[o] <= '0;
    end else if (strobes.wipe) begin
      holdValid <= 1'b0;
    end else if (sumValid) begin
      holdValid <= 1'b1;
      holdAddr  <= sumAddr;
      for (int o = 0; o < TOC; o++) begin
        holdSum[o] <= sameLoc ? holdSum[o] + $signed(sumFlat[o*ACCW +: ACCW])
                              : $signed(sumFlat[o*ACCW +: ACCW]);
      end
    end
  end

  // Output tile with per-location empty flags (one-cycle clear)
  logic signed [ACCW-1:0] tileMem [DEPTH][TOC];
  logic [DEPTH-1:0]       fresh;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fresh <= '1;
    end else if (strobes.wipe) begin
      fresh <= '1;
    end else if (memWe) begin
      fresh[holdAddr] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (memWe) begin
      for (int o = 0; o < TOC; o++) begin
        tileMem[holdAddr][o] <= fresh[holdAddr] ? holdSum[o]
                                                : tileMem[holdAddr][o] + holdSum[o];
      end
    end
  end

  // Read port: stored value plus any held partial sum, then saturation
  logic signed [ACCW-1:0] rdSum [TOC];
  logic                   rdHit;
  logic [TOC*DW-1:0]      rdQ;

  assign rdHit = holdValid && (holdAddr == rdAddr);

  always_comb begin
    for (int o = 0; o < TOC; o++) begin
      rdSum[o] = (fresh[rdAddr] ? '0 : tileMem[rdAddr][o])
               + (rdHit ? holdSum[o] : '0);
    end
  end

  function automatic logic [DW-1:0] satLane(input logic signed [ACCW-1:0] v);
    if (v > HIV)      satLane = HIV[DW-1:0];
    else if (v < LOV) satLane = LOV[DW-1:0];
    else              satLane = v[DW-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdQ <= '0;
    end else begin
      for (int o = 0; o < TOC; o++) rdQ[o*DW +: DW] <= satLane(rdSum[o]);
    end
  end

  assign rdData = rdQ;

  // R7
  wipe_drained_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wipe |-> !pipeBusy);
  // R3
  merged_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> (!memWe || (holdAddr != $past(holdAddr))));
  // R7
  wipe_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wipe |=> (!holdValid && (&fresh)));
endmodule

// File: rtl/dmac_ctrl.sv
module dmac_ctrl
  import dmac_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clearTile,
  input  logic        inValid,
  input  logic        pipeBusy,
  output logic        inReady,
  output dmacStrobe_t strobes
);
  typedef enum logic {ST_RUN, ST_DRAIN} ctrlState_t;
  ctrlState_t state, stateNext;

  assign inReady        = (state == ST_RUN) && !clearTile;
  assign strobes.accept = inValid && inReady;
  assign strobes.wipe   = (state == ST_DRAIN) && !pipeBusy;

  always_comb begin
    stateNext = state;
    case (state)
      ST_RUN:   if (clearTile) stateNext = ST_DRAIN;
      ST_DRAIN: if (!pipeBusy) stateNext = ST_RUN;
      default:  stateNext = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNext;
  end

  // R7
  clear_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clearTile && state == ST_RUN) |=> !inReady);
endmodule

// File: rtl/dmac_engine.sv
module dmac_engine
  import dmac_pkg::*;
#(
  parameter int DW    = 12,
  parameter int TIC   = 4,
  parameter int TOC   = 2,
  parameter int DEPTH = 16,
  parameter int GUARD = 4,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  clearTile,
  input  logic                  inValid,
  output logic                  inReady,
  input  logic [TIC*DW-1:0]     inPix,
  input  logic [TOC*TIC*DW-1:0] inWgt,
  input  logic [AW-1:0]         inAddr,
  input  logic [AW-1:0]         rdAddr,
  output logic [TOC*DW-1:0]     rdData
);
  dmacStrobe_t strobes;
  logic        pipeBusy;

  dmac_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clearTile (clearTile),
    .inValid   (inValid),
    .pipeBusy  (pipeBusy),
    .inReady   (inReady),
    .strobes   (strobes)
  );

  dmac_datapath #(.DW(DW), .TIC(TIC), .TOC(TOC), .DEPTH(DEPTH), .GUARD(GUARD)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inPix    (inPix),
    .inWgt    (inWgt),
    .inAddr   (inAddr),
    .rdAddr   (rdAddr),
    .rdData   (rdData),
    .pipeBusy (pipeBusy)
  );
endmodule

// File: tb/test_dmac_engine.sv
module test_dmac_engine;
  localparam int DW = 12, TIC = 4, TOC = 2, DEPTH = 16, AW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic clearTile = 1'b0;
  logic inValid = 1'b0;
  logic inReady;
  logic [TIC*DW-1:0]     inPix = '0;
  logic [TOC*TIC*DW-1:0] inWgt = '0;
  logic [AW-1:0]         inAddr = '0;
  logic [AW-1:0]         rdAddr = '0;
  logic [TOC*DW-1:0]     rdData;

  always #10 clk = ~clk;  // 50 MHz

  dmac_engine i_dmac_engine (
    .clk(clk), .rstN(rstN), .clearTile(clearTile), .inValid(inValid),
    .inReady(inReady), .inPix(inPix), .inWgt(inWgt), .inAddr(inAddr),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  int nRun = 0, nFail = 0;
  bit finished = 1'b0;
  longint model [DEPTH][TOC];
  int pixA [TIC];
  int wgtA [TOC][TIC];

  function automatic longint satB(longint v);
    if (v > 2047) return 2047;
    if (v < -2048) return -2048;
    return v;
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int a = 0; a < DEPTH; a++)
      for (int o = 0; o < TOC; o++) model[a][o] = 0;
  endtask

  function automatic logic [TOC*DW-1:0] expVec(int a);
    logic [TOC*DW-1:0] v;
    for (int o = 0; o < TOC; o++) v[o*DW +: DW] = DW'(satB(model[a][o]));
    return v;
  endfunction

  // Present one step from pixA/wgtA; returns at the negedge after the accepting edge
  task automatic doStep(int a);
    @(negedge clk);
    for (int i = 0; i < TIC; i++) inPix[i*DW +: DW] = DW'(pixA[i]);
    for (int o = 0; o < TOC; o++)
      for (int i = 0; i < TIC; i++) inWgt[(o*TIC+i)*DW +: DW] = DW'(wgtA[o][i]);
    inAddr  = AW'(a);
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    for (int o = 0; o < TOC; o++)
      for (int i = 0; i < TIC; i++) model[a][o] += longint'(pixA[i]) * wgtA[o][i];
  endtask

  task automatic fillAll(int p, int w);
    for (int i = 0; i < TIC; i++) pixA[i] = p;
    for (int o = 0; o < TOC; o++)
      for (int i = 0; i < TIC; i++) wgtA[o][i] = w;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic checkLoc(int a, string tag);
    rdAddr = AW'(a);
    @(negedge clk);
    check(rdData == expVec(a), tag, 64'(rdData), 64'(expVec(a)));
  endtask

  task automatic t_reset();
    check(inReady == 1'b1, "R1 ready after reset", 64'(inReady), 64'd1);
    for (int a = 0; a < DEPTH; a++) checkLoc(a, "R1 zero after reset");
  endtask

  task automatic t_single();
    pixA = '{1, -2, 3, 4};
    wgtA = '{'{5, 6, -7, 8}, '{-1, 2, 2, -3}};
    doStep(3);
    settle();
    checkLoc(3, "R2 single step lanes");
    checkLoc(4, "R2 neighbour untouched");
  endtask

  task automatic t_merge();
    pixA = '{10, 20, -30, 40};
    wgtA = '{'{1, 1, 1, 1}, '{2, -1, 0, 3}};
    doStep(7);
    pixA = '{-5, 7, 9, 11};
    wgtA = '{'{3, -4, 5, -6}, '{7, 7, 7, 7}};
    doStep(7);
    pixA = '{100, 0, -100, 1};
    doStep(7);
    settle();
    checkLoc(7, "R3 consecutive merge");
  endtask

  task automatic t_revisit();
    pixA = '{2, 3, 4, 5};
    wgtA = '{'{6, 7, 8, 9}, '{-9, -8, -7, -6}};
    doStep(9);
    doStep(10);
    pixA = '{-11, 13, 0, 17};
    doStep(9);
    doStep(10);
    settle();
    checkLoc(9, "R4 revisit 9");
    checkLoc(10, "R4 revisit 10");
  endtask

  task automatic t_sat();
    fillAll(2047, 2047);
    doStep(12);
    settle();
    checkLoc(12, "R5 positive clamp");
    fillAll(2047, -2047);
    doStep(12);
    settle();
    checkLoc(12, "R5 guard bits exact return");
    fillAll(-2048, 2047);
    doStep(13);
    settle();
    checkLoc(13, "R5 negative clamp");
  endtask

  task automatic t_bubble();
    @(negedge clk);
    inValid = 1'b0;
    inPix = {TIC{12'h123}};
    inWgt = {TOC*TIC{12'h045}};
    inAddr = 4'd2;
    repeat (5) @(negedge clk);
    settle();
    checkLoc(2, "R6 idle inputs ignored");
    pixA = '{4, 4, 4, 4};
    wgtA = '{'{1, 2, 3, 4}, '{5, 6, 7, 8}};
    doStep(1);
    repeat (3) @(negedge clk);
    doStep(1);
    settle();
    checkLoc(1, "R6 gapped steps counted once");
  endtask

  task automatic t_latency();
    logic [TOC*DW-1:0] oldV;
    rdAddr = 4'd5;
    @(negedge clk);
    oldV = expVec(5);
    pixA = '{3, 1, 4, 1};
    wgtA = '{'{5, 9, 2, 6}, '{-5, 3, 5, -8}};
    doStep(5);               // now after edge n
    @(negedge clk);          // after n+1
    @(negedge clk);          // after n+2
    check(rdData == oldV, "R9 not yet visible at n+2", 64'(rdData), 64'(oldV));
    @(negedge clk);          // after n+3
    check(rdData == expVec(5), "R9 visible at n+3", 64'(rdData), 64'(expVec(5)));
    doStep(5);
    repeat (3) @(negedge clk);
    check(rdData == expVec(5), "R8 held sum forwarded", 64'(rdData), 64'(expVec(5)));
  endtask

  task automatic t_clear();
    pixA = '{9, 9, 9, 9};
    wgtA = '{'{1, 1, 1, 1}, '{2, 2, 2, 2}};
    doStep(6);
    clearTile = 1'b1;
    @(negedge clk);
    clearTile = 1'b0;
    check(inReady == 1'b0, "R7 ready low while draining", 64'(inReady), 64'd0);
    while (!inReady) @(negedge clk);
    modelClear();
    for (int a = 0; a < DEPTH; a++) checkLoc(a, "R7 tile zero after clear");
    pixA = '{1, 2, 3, 4};
    wgtA = '{'{1, 0, 0, 0}, '{0, 0, 0, 1}};
    doStep(6);
    settle();
    checkLoc(6, "R7 fresh accumulation after clear");
  endtask

  initial begin
    modelClear();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_merge();
    t_revisit();
    t_sat();
    t_bubble();
    t_latency();
    t_clear();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog expired actual=hang expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule